// File: doc/BRIEF.md
# Variable Page Size Unified Translation Buffer

This block translates 32-bit effective addresses to physical addresses for both instruction and data accesses. It holds a fully associative array of software-loaded entries. Each entry carries a high word (effective page, page size code, valid flag), a low word (physical page) and a translation ID. Each entry picks one of eight page sizes, from 1 KB to 16 MB.

A lookup request compares the address against every entry in parallel. An entry takes part only when it is valid and its translation ID equals the current process ID register. Each entry uses the compare mask that its own size code selects. When several entries match, the one with the lowest index wins. A miss produces a translation-fault indication. When translation is disabled, the address passes straight through. Software loads entries one at a time by index and sets the process ID through a separate write strobe. The lookup result is registered and appears one cycle after the request.

Top module: `vps_tlb`

## Requirements
- R1: After reset every entry is invalid, so a translated lookup faults. `rsp_valid`, `rsp_hit` and `rsp_fault` are 0 during reset.
- R2: The size code sits in high-word bits [9:7]. Code n selects the mask that keeps address bits [31:10+2n], giving page sizes 1 KB, 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB and 16 MB for codes 0 to 7.
- R3: An entry takes part in a lookup only if its valid flag (high-word bit 6) is 1 and its translation ID equals the process ID register. A process ID write with `pid_we` takes effect on the following cycle.
- R4: An entry matches when (address AND mask) equals (high word AND mask). On a hit, the physical address is (low word AND mask) OR (address AND NOT mask).
- R5: When several entries match, the entry with the lowest index is used, and its index is reported on `rsp_idx`.
- R6: With `xlat_en` low, a lookup returns the address unchanged with `rsp_hit` = 1 and `rsp_fault` = 0.
- R7: A translated lookup with no matching entry gives `rsp_fault` = 1, `rsp_hit` = 0 and `rsp_paddr` = 0. Hit and fault are never both 1.
- R8: An entry write with `wr_en` takes effect on the next cycle. A lookup in the same cycle as the write sees the old contents.
- R9: `rsp_valid` is 1 exactly in the cycle after a cycle with `lk_valid` = 1, and the result fields belong to that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Index of the entry to write |
| wr_hi | input | 32 | High word: effective page [31:10], size code [9:7], valid [6] |
| wr_lo | input | 32 | Low word: physical page |
| wr_tid | input | 8 | Translation ID of the entry |
| pid_we | input | 1 | Process ID write strobe |
| pid_wdata | input | 8 | New process ID |
| xlat_en | input | 1 | Translation enable for this lookup |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Effective address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Translation succeeded (or passthrough) |
| rsp_fault | output | 1 | No matching entry |
| rsp_paddr | output | 32 | Physical address |
| rsp_idx | output | 6 | Index of the entry used |

## Verification
The size sweep loads one entry per size code. It probes the highest offset bit, which must hit and carry through to the physical address. It then probes the lowest compared bit, which must miss. Together these pin each mask to its exact boundary.

Overlapping 4 KB and 16 MB entries separate lowest-index priority from size-based choice. A translation ID that differs from the process ID, and a cleared valid flag, separate the two participation conditions. A lookup issued in the same cycle as an entry write or a process ID write separates old-contents behaviour from write-through.

// File: rtl/vps_tlb_pkg.sv
package vps_tlb_pkg;

  localparam int VA_W          = 32;
  localparam int SIZE_W        = 3;
  localparam int HI_SIZE_LSB   = 7;
  localparam int HI_VALID_BIT  = 6;
  localparam int MIN_PAGE_BITS = 10;

  // Compare mask for a size code: code n keeps bits [31:10+2n].
  function automatic logic [VA_W-1:0] size_mask(input logic [SIZE_W-1:0] code);
    logic [VA_W-1:0] m;
    case (code)
      3'd0: m = 32'hFFFF_FC00;
      3'd1: m = 32'hFFFF_F000;
      3'd2: m = 32'hFFFF_C000;
      3'd3: m = 32'hFFFF_0000;
      3'd4: m = 32'hFFFC_0000;
      3'd5: m = 32'hFFF0_0000;
      3'd6: m = 32'hFFC0_0000;
      default: m = 32'hFF00_0000;
    endcase
    return m;
  endfunction

  // Page base from the low word, page offset from the address.
  function automatic logic [VA_W-1:0] merge_pa(input logic [VA_W-1:0] base,
                                               input logic [VA_W-1:0] addr,
                                               input logic [VA_W-1:0] mask);
    return (base & mask) | (addr & ~mask);
  endfunction

  function automatic logic page_eq(input logic [VA_W-1:0] a,
                                   input logic [VA_W-1:0] b,
                                   input logic [VA_W-1:0] mask);
    return (a & mask) == (b & mask);
  endfunction

endpackage

// File: rtl/vps_tlb_entries.sv
module vps_tlb_entries
  import vps_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [VA_W-1:0]                wr_hi,
  input  logic [VA_W-1:0]                wr_lo,
  input  logic [TID_W-1:0]               wr_tid,
  input  logic [TID_W-1:0]               pid,
  input  logic [VA_W-1:0]                addr,
  output logic [ENTRIES-1:0]             valid_vec,
  output logic [ENTRIES-1:0]             match_vec,
  output logic [ENTRIES-1:0][VA_W-1:0]   pa_vec
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [VA_W-1:0]  hi_q;
    logic [VA_W-1:0]  lo_q;
    logic [TID_W-1:0] tid_q;
    logic [VA_W-1:0]  msk;
    logic             owner_ok;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_q  <= '0;
        lo_q  <= '0;
        tid_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        hi_q  <= wr_hi;
        lo_q  <= wr_lo;
        tid_q <= wr_tid;
      end
    end

    assign msk          = size_mask(hi_q[HI_SIZE_LSB +: SIZE_W]);
    assign valid_vec[e] = hi_q[HI_VALID_BIT];
    assign owner_ok     = (tid_q == pid);
    assign match_vec[e] = valid_vec[e] && owner_ok && page_eq(addr, hi_q, msk);
    assign pa_vec[e]    = merge_pa(lo_q, addr, msk);
  end

endmodule

// File: rtl/vps_tlb_pick.sv
module vps_tlb_pick #(
  parameter int N      = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     onehot
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    onehot = found ? ({{(N-1){1'b0}}, 1'b1} << idx) : '0;
  end

endmodule

// File: rtl/vps_tlb.sv
module vps_tlb
  import vps_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_hi,
  input  logic [31:0]      wr_lo,
  input  logic [TID_W-1:0] wr_tid,
  input  logic             pid_we,
  input  logic [TID_W-1:0] pid_wdata,
  input  logic             xlat_en,
  input  logic             lk_valid,
  input  logic [31:0]      lk_addr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [31:0]      rsp_paddr,
  output logic [IDX_W-1:0] rsp_idx
);

  logic [TID_W-1:0]              pid_q;
  logic [ENTRIES-1:0]            valid_vec;
  logic [ENTRIES-1:0]            match_vec;
  logic [ENTRIES-1:0][VA_W-1:0]  pa_vec;
  logic                          pick_found;
  logic [IDX_W-1:0]              pick_idx;
  logic [ENTRIES-1:0]            pick_onehot;
  logic [VA_W-1:0]               pick_pa;

  always_ff @(posedge clk) begin
    if (!rst_n)      pid_q <= '0;
    else if (pid_we) pid_q <= pid_wdata;
  end

  vps_tlb_entries #(.ENTRIES(ENTRIES), .TID_W(TID_W)) u_entries (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_hi     (wr_hi),
    .wr_lo     (wr_lo),
    .wr_tid    (wr_tid),
    .pid       (pid_q),
    .addr      (lk_addr),
    .valid_vec (valid_vec),
    .match_vec (match_vec),
    .pa_vec    (pa_vec)
  );

  vps_tlb_pick #(.N(ENTRIES)) u_pick (
    .req    (match_vec),
    .found  (pick_found),
    .idx    (pick_idx),
    .onehot (pick_onehot)
  );

  assign pick_pa = pa_vec[pick_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rsp_idx   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rsp_idx   <= '0;
      if (lk_valid) begin
        if (!xlat_en) begin
          rsp_hit   <= 1'b1;
          rsp_paddr <= lk_addr;
        end else if (pick_found) begin
          rsp_hit   <= 1'b1;
          rsp_paddr <= pick_pa;
          rsp_idx   <= pick_idx;
        end else begin
          rsp_fault <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vps_tlb_checker.sv
module vps_tlb_checker #(
  parameter int ENTRIES = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               xlat_en,
  input logic [31:0]        lk_addr,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_fault,
  input logic [31:0]        rsp_paddr,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] match_vec,
  input logic               pick_found,
  input logic [ENTRIES-1:0] pick_onehot
);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (valid_vec == '0));

  p_valid_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_vec & ~valid_vec) == '0));

  p_pick_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_onehot));

  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pick_found |-> (((match_vec & pick_onehot) != '0) &&
                    ((match_vec & (pick_onehot - 1'b1)) == '0)));

  p_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !xlat_en) |=> (rsp_hit && !rsp_fault && rsp_paddr == $past(lk_addr)));

  p_miss_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && xlat_en && !pick_found) |=> (rsp_fault && !rsp_hit && rsp_paddr == '0));

  p_hit_fault_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));

  p_resp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  p_resp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault));

endmodule

bind vps_tlb vps_tlb_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .xlat_en     (xlat_en),
  .lk_addr     (lk_addr),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_fault   (rsp_fault),
  .rsp_paddr   (rsp_paddr),
  .valid_vec   (valid_vec),
  .match_vec   (match_vec),
  .pick_found  (pick_found),
  .pick_onehot (pick_onehot)
);

// File: tb/vps_tlb_test.sv
`timescale 1ns/1ps
module vps_tlb_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_hi = '0;
  logic [31:0] wr_lo = '0;
  logic [7:0]  wr_tid = '0;
  logic        pid_we = 1'b0;
  logic [7:0]  pid_wdata = '0;
  logic        xlat_en = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [5:0]  rsp_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  vps_tlb uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hi_word(input logic [31:0] page, input int code, input bit v);
    return (page & (32'hFFFF_FFFF << (10 + 2 * code))) | (32'(code) << 7) | (32'(v) << 6);
  endfunction

  task automatic write_entry(input int idx, input logic [31:0] hi,
                             input logic [31:0] lo, input logic [7:0] tid);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_hi = hi; wr_lo = lo; wr_tid = tid;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Result registered at the next edge; sampled at the following negedge.
  task automatic lookup(input logic [31:0] a, input bit en);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; xlat_en = en;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] pa, input int idx);
    check(req, {31'b0, rsp_hit}, 32'd1);
    check(req, {31'b0, rsp_fault}, 32'd0);
    check(req, rsp_paddr, pa);
    check(req, {26'b0, rsp_idx}, 32'(idx));
  endtask

  task automatic expect_fault(input string req);
    check(req, {31'b0, rsp_valid}, 32'd1);
    check(req, {31'b0, rsp_fault}, 32'd1);
    check(req, {31'b0, rsp_hit}, 32'd0);
    check(req, rsp_paddr, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R1 reset rsp_fault", {31'b0, rsp_fault}, 32'd0);
    lookup(32'h0000_0000, 1'b1);
    expect_fault("R1 empty after reset");
    lookup(32'hFFFF_FC00, 1'b1);
    expect_fault("R1 empty after reset hi");
  endtask

  task automatic t_passthru;
    lookup(32'h1234_5678, 1'b0);
    check("R9 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    expect_hit("R6 passthrough", 32'h1234_5678, 0);
    lookup(32'hFEDC_BA98, 1'b0);
    expect_hit("R6 passthrough 2", 32'hFEDC_BA98, 0);
  endtask

  task automatic t_sizes;
    logic [31:0] va, lo, m, probe;
    va = 32'hC3A5_5A5C;
    lo = 32'h1E6D_B400;
    for (int c = 0; c < 8; c++) begin
      m = 32'hFFFF_FFFF << (10 + 2 * c);
      write_entry(0, hi_word(va, c, 1'b1), lo, 8'h00);
      probe = va ^ (32'd1 << (9 + 2 * c));
      lookup(probe, 1'b1);
      expect_hit($sformatf("R2 R4 size %0d inside", c), (lo & m) | (probe & ~m), 0);
      probe = va ^ (32'd1 << (10 + 2 * c));
      lookup(probe, 1'b1);
      expect_fault($sformatf("R2 R4 size %0d outside", c));
    end
    write_entry(0, 32'h0, 32'h0, 8'h00);
  endtask

  task automatic t_priority;
    write_entry(20, hi_word(32'h7700_0000, 7, 1'b1), 32'h0800_0000, 8'h00);
    write_entry(10, hi_word(32'h7712_3000, 1, 1'b1), 32'h0009_A000, 8'h00);
    lookup(32'h7712_3ABC, 1'b1);
    expect_hit("R5 lowest index", 32'h0009_AABC, 10);
    write_entry(10, 32'h0, 32'h0, 8'h00);
    lookup(32'h7712_3ABC, 1'b1);
    expect_hit("R5 next index", 32'h0812_3ABC, 20);
    write_entry(20, 32'h0, 32'h0, 8'h00);
    lookup(32'h7712_3ABC, 1'b1);
    expect_fault("R7 cleared");
  endtask

  task automatic t_pid;
    write_entry(3, hi_word(32'h4000_1000, 1, 1'b1), 32'h0055_5000, 8'h5A);
    lookup(32'h4000_1234, 1'b1);
    expect_fault("R3 tid mismatch");
    @(negedge clk);
    pid_we = 1'b1; pid_wdata = 8'h5A;
    lk_valid = 1'b1; lk_addr = 32'h4000_1234; xlat_en = 1'b1;
    @(negedge clk);
    pid_we = 1'b0; lk_valid = 1'b0;
    expect_fault("R3 pid write same cycle");
    lookup(32'h4000_1234, 1'b1);
    expect_hit("R3 tid match", 32'h0055_5234, 3);
    write_entry(3, hi_word(32'h4000_1000, 1, 1'b0), 32'h0055_5000, 8'h5A);
    lookup(32'h4000_1234, 1'b1);
    expect_fault("R3 valid clear");
  endtask

  task automatic t_write_timing;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd5; wr_hi = hi_word(32'h6000_0000, 0, 1'b1);
    wr_lo = 32'h0000_2C00; wr_tid = 8'h5A;
    lk_valid = 1'b1; lk_addr = 32'h6000_0123; xlat_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    expect_fault("R8 same cycle old contents");
    @(negedge clk);
    check("R9 idle no response", {31'b0, rsp_valid}, 32'd0);
    lookup(32'h6000_0123, 1'b1);
    expect_hit("R8 after write", 32'h0000_2D23, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre: begin
      check("R1 in reset rsp_hit", {31'b0, rsp_hit}, 32'd0);
    end
    rst_n = 1'b1;
    t_reset();
    t_passthru();
    t_sizes();
    t_priority();
    t_pid();
    t_write_timing();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule